// File: doc/BRIEF.md
# Host Register Window with Buffer RAM Pointer

This block is the host-facing register window of a network controller. Through eight byte-wide host addresses, software loads an 11-bit pointer into a 2K x 8 buffer RAM. It then streams bytes through a single data port. A direction bit in the pointer-high register selects read or write, and an auto-increment bit steps the pointer after each data-port access. In read direction the block keeps one byte ahead. Loading the pointer fetches the addressed byte into a prefetch register, and each auto-incrementing read fetches the following byte.

One host address is an indirect window. A 3-bit sub-address chooses which register the window reaches: tentative ID, node ID, two setup registers, or a read-only next-ID register. The two low sub-address bits share storage with the low two bits of the configuration register. Any configuration write forces the top sub-address bit to zero.

Configuration bit 7 is a level-held software reset, which is also brought out to the protocol engine. While it is set, the status, diagnostic and next-ID registers are held at zero. All other state is left alone.

Top module: `hrw_top`

## Requirements
- R1: After the hardware reset, every host address reads 0x00.
- R2: Pointer-high (address 2) stores bit 7 = direction (1 read, 0 write), bit 6 = auto-increment and bits 2..0 = pointer bits 10..8; its bits 5..3 read 0. Pointer-low (address 3) holds pointer bits 7..0.
- R3: A data-port (address 4) write in write direction stores the byte at the pointer; with auto-increment on, the pointer then advances by one and wraps from 0x7FF to 0x000.
- R4: With auto-increment off, data-port accesses leave the pointer unchanged.
- R5: A pointer-high or pointer-low write that leaves the direction at read fetches the byte at the new pointer. A data-port read returns the fetched byte. With auto-increment on, the read then fetches the byte at the advanced pointer.
- R6: A data-port write in read direction changes neither RAM nor pointer. A data-port read in write direction does not move the pointer.
- R7: The sub-address register (address 5, bits 2..0) selects the register behind the window (address 7): 000 tentative ID, 001 node ID, 010 setup 1, 100 setup 2 (all read/write), 011 next ID.
- R8: Sub-address bits 1..0 and configuration (address 6) bits 1..0 are one storage; a write to either address updates both readbacks.
- R9: Every configuration write clears sub-address bit 2.
- R10: At sub-addresses 101, 110 and 111 the window reads 0x00 and ignores writes. Host writes at sub-address 011 leave next ID unchanged.
- R11: While configuration bit 7 is 1, `soft_rst` is high and status, diagnostic and next ID read 0x00 and ignore their inputs. The configuration, pointer and read/write indirect registers keep their values. Writing bit 7 back to 0 releases the hold.
- R12: Outside software reset, status (address 0) and diagnostic (address 1) bits are set by one-cycle event pulses and stay set. A `nid_load` pulse loads `nid_value` into next ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle (side effects at the data port only) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| evt_status | input | 8 | Status bit set pulses |
| evt_diag | input | 8 | Diagnostic bit set pulses |
| nid_load | input | 1 | Load strobe for next ID |
| nid_value | input | 8 | Next ID from the protocol engine |
| soft_rst | output | 1 | Software reset level (configuration bit 7) |

## Verification
The assertions assume that the host never raises its write and read strobes in the same cycle. They also assume at least one idle cycle between a pointer write or data-port read and the next data-port read, which gives the prefetch time to land. The bench drives every access through tasks that hold one strobe for a single cycle and then idle one cycle, so both assumptions hold throughout the random phase. Event pulses are issued only between host accesses.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
  typedef enum logic [2:0] {
    REG_STAT = 3'd0,
    REG_DIAG = 3'd1,
    REG_PHI  = 3'd2,
    REG_PLO  = 3'd3,
    REG_DATA = 3'd4,
    REG_SUB  = 3'd5,
    REG_CFG  = 3'd6,
    REG_IND  = 3'd7
  } hreg_e;

  typedef enum logic [2:0] {
    SA_TENT = 3'd0,
    SA_NODE = 3'd1,
    SA_SET1 = 3'd2,
    SA_NEXT = 3'd3,
    SA_SET2 = 3'd4
  } subsel_e;

  localparam int N_RW_SLOTS = 4;
endpackage

// File: rtl/hrw_ptr.sv
module hrw_ptr #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] ptr,
  output logic          dir_rd,
  output logic          auto_inc,
  output logic          fetch,
  output logic          ram_we
);
  localparam int LW  = 8;
  localparam int HIW = AW - LW;

  logic [AW-1:0] ptr_q, ptr_n;
  logic          dir_q, dir_n, ainc_q, ainc_n, fetch_q, fetch_n;
  logic          step;

  always_comb begin
    ptr_n  = ptr_q;
    dir_n  = dir_q;
    ainc_n = ainc_q;
    if (wr_hi) begin
      dir_n             = wdata[DW-1];
      ainc_n            = wdata[DW-2];
      ptr_n[AW-1:LW]    = wdata[HIW-1:0];
    end
    if (wr_lo) ptr_n[LW-1:0] = wdata[LW-1:0];
    step = ainc_q && ((dat_rd && dir_q) || (dat_wr && !dir_q));
    if (step) ptr_n = ptr_q + AW'(1);
    fetch_n = (wr_hi && wdata[DW-1]) || (wr_lo && dir_q) ||
              (dat_rd && dir_q && ainc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      dir_q   <= 1'b0;
      ainc_q  <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_n;
      dir_q   <= dir_n;
      ainc_q  <= ainc_n;
      fetch_q <= fetch_n;
    end
  end

  assign ptr      = ptr_q;
  assign dir_rd   = dir_q;
  assign auto_inc = ainc_q;
  assign fetch    = fetch_q;
  assign ram_we   = dat_wr && !dir_q;
endmodule

// File: rtl/hrw_ram.sv
module hrw_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wd,
  input  logic          re,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (re) q_q <= mem[addr];
  end

  assign q = q_q;
endmodule

// File: rtl/hrw_regs.sv
module hrw_regs
  import hrw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sub,
  input  logic          wr_cfg,
  input  logic          wr_ind,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_status,
  input  logic [DW-1:0] evt_diag,
  input  logic          nid_load,
  input  logic [DW-1:0] nid_value,
  output logic [2:0]    sub,
  output logic [DW-1:0] cfg,
  output logic [DW-1:0] status,
  output logic [DW-1:0] diag,
  output logic [DW-1:0] next_id,
  output logic [DW-1:0] ind_rdata,
  output logic          srst
);
  localparam int CHW = DW - 2;

  logic [CHW-1:0] cfg_hi_q, cfg_hi_n;
  logic [1:0]     sub_lo_q, sub_lo_n;
  logic           sub2_q, sub2_n;
  logic [DW-1:0]  stat_q, stat_n, diag_q, diag_n, nid_q, nid_n;
  logic [DW-1:0]  slot_val [N_RW_SLOTS];

  always_comb begin
    cfg_hi_n = cfg_hi_q;
    sub_lo_n = sub_lo_q;
    sub2_n   = sub2_q;
    if (wr_cfg) begin
      cfg_hi_n = wdata[DW-1:2];
      sub_lo_n = wdata[1:0];
      sub2_n   = 1'b0;
    end else if (wr_sub) begin
      sub_lo_n = wdata[1:0];
      sub2_n   = wdata[2];
    end
  end

  assign srst = cfg_hi_q[CHW-1];

  always_comb begin
    stat_n = srst ? '0 : (stat_q | evt_status);
    diag_n = srst ? '0 : (diag_q | evt_diag);
    nid_n  = srst ? '0 : (nid_load ? nid_value : nid_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_hi_q <= '0;
      sub_lo_q <= '0;
      sub2_q   <= 1'b0;
      stat_q   <= '0;
      diag_q   <= '0;
      nid_q    <= '0;
    end else begin
      cfg_hi_q <= cfg_hi_n;
      sub_lo_q <= sub_lo_n;
      sub2_q   <= sub2_n;
      stat_q   <= stat_n;
      diag_q   <= diag_n;
      nid_q    <= nid_n;
    end
  end

  for (genvar g = 0; g < N_RW_SLOTS; g++) begin : g_slot
    localparam logic [2:0] CODE = (g == N_RW_SLOTS - 1) ? 3'(SA_SET2) : 3'(g);
    logic [DW-1:0] q, n;
    always_comb n = (wr_ind && ({sub2_q, sub_lo_q} == CODE)) ? wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= n;
    end
    assign slot_val[g] = q;
  end

  always_comb begin
    case ({sub2_q, sub_lo_q})
      SA_TENT: ind_rdata = slot_val[0];
      SA_NODE: ind_rdata = slot_val[1];
      SA_SET1: ind_rdata = slot_val[2];
      SA_NEXT: ind_rdata = nid_q;
      SA_SET2: ind_rdata = slot_val[3];
      default: ind_rdata = '0;
    endcase
  end

  assign sub     = {sub2_q, sub_lo_q};
  assign cfg     = {cfg_hi_q, sub_lo_q};
  assign status  = stat_q;
  assign diag    = diag_q;
  assign next_id = nid_q;
endmodule

// File: rtl/hrw_top.sv
module hrw_top
  import hrw_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] evt_status,
  input  logic [DW-1:0] evt_diag,
  input  logic          nid_load,
  input  logic [DW-1:0] nid_value,
  output logic          soft_rst
);
  localparam int LW  = 8;
  localparam int HIW = AW - LW;
  localparam int PAD = DW - 2 - HIW;

  logic          wr_hi, wr_lo, wr_sub, wr_cfg, wr_ind, dat_rd, dat_wr;
  logic [AW-1:0] ptr;
  logic          dir_rd, auto_inc, fetch, ram_we;
  logic [DW-1:0] ram_q, cfg, status, diag, next_id, ind_rdata;
  logic [2:0]    sub;

  assign wr_hi  = host_wr && (host_addr == REG_PHI);
  assign wr_lo  = host_wr && (host_addr == REG_PLO);
  assign wr_sub = host_wr && (host_addr == REG_SUB);
  assign wr_cfg = host_wr && (host_addr == REG_CFG);
  assign wr_ind = host_wr && (host_addr == REG_IND);
  assign dat_wr = host_wr && (host_addr == REG_DATA);
  assign dat_rd = host_rd && (host_addr == REG_DATA);

  hrw_ptr #(.AW(AW), .DW(DW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .wdata(host_wdata),
    .ptr(ptr), .dir_rd(dir_rd), .auto_inc(auto_inc),
    .fetch(fetch), .ram_we(ram_we)
  );

  hrw_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n), .addr(ptr), .we(ram_we),
    .wd(host_wdata), .re(fetch), .q(ram_q)
  );

  hrw_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_sub(wr_sub), .wr_cfg(wr_cfg),
    .wr_ind(wr_ind), .wdata(host_wdata), .evt_status(evt_status),
    .evt_diag(evt_diag), .nid_load(nid_load), .nid_value(nid_value),
    .sub(sub), .cfg(cfg), .status(status), .diag(diag),
    .next_id(next_id), .ind_rdata(ind_rdata), .srst(soft_rst)
  );

  always_comb begin
    case (host_addr)
      REG_STAT: host_rdata = status;
      REG_DIAG: host_rdata = diag;
      REG_PHI:  host_rdata = {dir_rd, auto_inc, {PAD{1'b0}}, ptr[AW-1:LW]};
      REG_PLO:  host_rdata = ptr[LW-1:0];
      REG_DATA: host_rdata = ram_q;
      REG_SUB:  host_rdata = {{(DW-3){1'b0}}, sub};
      REG_CFG:  host_rdata = cfg;
      default:  host_rdata = ind_rdata;
    endcase
  end
endmodule

// File: rtl/hrw_chk.sv
module hrw_chk
  import hrw_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    host_addr,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_wdata,
  input logic [DW-1:0] host_rdata,
  input logic [AW-1:0] ptr,
  input logic          dir_rd,
  input logic          auto_inc,
  input logic [2:0]    sub,
  input logic [DW-1:0] cfg,
  input logic [DW-1:0] status,
  input logic [DW-1:0] diag,
  input logic [DW-1:0] next_id,
  input logic          soft_rst
);
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == REG_DATA && !dir_rd && auto_inc && ptr == '1)
      |=> (ptr == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && host_addr == REG_DATA && !auto_inc)
      |=> $stable(ptr));

  a_r6_no_store_move: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == REG_DATA && dir_rd) |=> $stable(ptr));

  a_r8_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == REG_SUB) |=> (cfg[1:0] == $past(host_wdata[1:0])));

  a_r9_sub2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == REG_CFG) |=> (sub[2] == 1'b0));

  a_r10_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == REG_IND && sub > 3'd4) |-> (host_rdata == '0));

  a_r11_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == '0 && diag == '0 && next_id == '0));

  a_r11_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && (host_addr == REG_CFG || host_addr == REG_SUB)) |=> $stable(cfg));

  a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == REG_PHI) |-> (host_rdata[DW-3:AW-8] == '0));
endmodule

bind hrw_top hrw_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .ptr(ptr), .dir_rd(dir_rd), .auto_inc(auto_inc), .sub(sub), .cfg(cfg),
  .status(status), .diag(diag), .next_id(next_id), .soft_rst(soft_rst)
);

// File: tb/tb_hrw_top.sv
module tb_hrw_top;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam time TCK = 8ns;

  logic       clk, rst_n;
  logic [2:0] host_addr;
  logic       host_wr, host_rd, nid_load, soft_rst;
  logic [7:0] host_wdata, host_rdata, evt_status, evt_diag, nid_value;

  hrw_top dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_status(evt_status), .evt_diag(evt_diag), .nid_load(nid_load),
    .nid_value(nid_value), .soft_rst(soft_rst)
  );

  int n_tests = 0, n_fail = 0;

  // reference state
  logic [7:0]    m_mem [DEPTH];
  logic [AW-1:0] m_ptr;
  logic          m_dir, m_ainc, m_sub2;
  logic [1:0]    m_sublo;
  logic [5:0]    m_cfghi;
  logic [7:0]    m_latch, m_stat, m_diag, m_next;
  logic [7:0]    m_ind [8];

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [2:0] a);
    logic [2:0] s;
    s = {m_sub2, m_sublo};
    case (a)
      3'd0: return m_stat;
      3'd1: return m_diag;
      3'd2: return {m_dir, m_ainc, 3'b000, m_ptr[10:8]};
      3'd3: return m_ptr[7:0];
      3'd4: return m_latch;
      3'd5: return {5'b0, s};
      3'd6: return {m_cfghi, m_sublo};
      default: begin
        if (s == 3'd3) return m_next;
        if (s == 3'd0 || s == 3'd1 || s == 3'd2 || s == 3'd4) return m_ind[s];
        return 8'h00;
      end
    endcase
  endfunction

  task automatic m_write(input logic [2:0] a, input logic [7:0] d);
    logic [2:0] s;
    s = {m_sub2, m_sublo};
    case (a)
      3'd2: begin
        m_dir = d[7]; m_ainc = d[6]; m_ptr[10:8] = d[2:0];
        if (m_dir) m_latch = m_mem[m_ptr];
      end
      3'd3: begin
        m_ptr[7:0] = d;
        if (m_dir) m_latch = m_mem[m_ptr];
      end
      3'd4: if (!m_dir) begin
        m_mem[m_ptr] = d;
        if (m_ainc) m_ptr = m_ptr + 1'b1;
      end
      3'd5: begin m_sub2 = d[2]; m_sublo = d[1:0]; end
      3'd6: begin
        m_cfghi = d[7:2]; m_sublo = d[1:0]; m_sub2 = 1'b0;
        if (d[7]) begin m_stat = 0; m_diag = 0; m_next = 0; end
      end
      3'd7: if (s == 3'd0 || s == 3'd1 || s == 3'd2 || s == 3'd4) m_ind[s] = d;
      default: ;
    endcase
  endtask

  task automatic op_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    m_write(a, d);
    @(negedge clk);
  endtask

  task automatic op_rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #2;
    chk(host_rdata, m_read(a), tag);
    @(negedge clk);
    host_rd = 1'b0;
    if (a == 3'd4 && m_dir && m_ainc) begin
      m_ptr = m_ptr + 1'b1;
      m_latch = m_mem[m_ptr];
    end
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [7:0] es, input logic [7:0] ed,
                           input logic ld, input logic [7:0] nv);
    @(negedge clk);
    evt_status = es; evt_diag = ed; nid_load = ld; nid_value = nv;
    @(negedge clk);
    evt_status = 0; evt_diag = 0; nid_load = 0;
    if (m_cfghi[5] == 1'b0) begin
      m_stat |= es; m_diag |= ed;
      if (ld) m_next = nv;
    end
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20250611));
    host_addr = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
    evt_status = 0; evt_diag = 0; nid_load = 0; nid_value = 0;
    m_ptr = 0; m_dir = 0; m_ainc = 0; m_sub2 = 0; m_sublo = 0; m_cfghi = 0;
    m_latch = 0; m_stat = 0; m_diag = 0; m_next = 0;
    for (int i = 0; i < 8; i++) m_ind[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values at every address
    for (int a = 0; a < 8; a++) op_rd(3'(a), "R1 reset value");

    // R2: pointer registers and padding bits
    op_wr(3'd2, 8'hFF);
    op_rd(3'd2, "R2 ptr-high pad reads zero");
    op_wr(3'd2, 8'h05);
    op_wr(3'd3, 8'hA7);
    op_rd(3'd2, "R2 ptr-high fields");
    op_rd(3'd3, "R2 ptr-low");

    // R3: fill RAM in write direction with auto-increment, ending with wrap
    op_wr(3'd2, 8'h40);
    op_wr(3'd3, 8'h00);
    for (int i = 0; i < DEPTH; i++) op_wr(3'd4, 8'(i * 7 + 3));
    op_rd(3'd2, "R3 wrap high");
    op_rd(3'd3, "R3 wrap low");

    // R4: auto-increment off keeps pointer
    op_wr(3'd2, 8'h01);
    op_wr(3'd3, 8'h10);
    op_wr(3'd4, 8'h5A);
    op_wr(3'd4, 8'h6B);
    op_rd(3'd3, "R4 hold after writes");
    op_rd(3'd4, "R4 read in write direction");
    op_rd(3'd3, "R6 read in write direction keeps pointer");

    // R5: prefetch, auto-increment read and wrap on read
    op_wr(3'd2, 8'hC1);
    op_wr(3'd3, 8'h10);
    op_rd(3'd4, "R5 prefetch after pointer write");
    op_rd(3'd4, "R5 next byte");
    op_rd(3'd4, "R5 third byte");
    op_wr(3'd2, 8'hC7);
    op_wr(3'd3, 8'hFF);
    op_rd(3'd4, "R5 byte at 0x7FF");
    op_rd(3'd4, "R5 byte after read wrap");
    op_rd(3'd3, "R3 read wrap pointer low");
    op_wr(3'd2, 8'h80);
    op_wr(3'd3, 8'h20);
    op_rd(3'd4, "R5 non-incrementing read");
    op_rd(3'd4, "R5 repeated byte");
    op_rd(3'd3, "R4 hold after reads");

    // R6: data write in read direction is ignored
    op_wr(3'd4, 8'hEE);
    op_rd(3'd3, "R6 pointer unchanged");
    op_wr(3'd3, 8'h20);
    op_rd(3'd4, "R6 RAM unchanged");

    // R7: indirect registers
    op_wr(3'd5, 8'h00); op_wr(3'd7, 8'h11);
    op_wr(3'd5, 8'h01); op_wr(3'd7, 8'h22);
    op_wr(3'd5, 8'h02); op_wr(3'd7, 8'h33);
    op_wr(3'd5, 8'h04); op_wr(3'd7, 8'h44);
    op_rd(3'd7, "R7 setup 2");
    op_wr(3'd5, 8'h00); op_rd(3'd7, "R7 tentative ID");
    op_wr(3'd5, 8'h01); op_rd(3'd7, "R7 node ID");
    op_wr(3'd5, 8'h02); op_rd(3'd7, "R7 setup 1");

    // R8 / R9: shared low bits, top bit cleared by config write
    op_wr(3'd5, 8'h07);
    op_rd(3'd6, "R8 config low bits follow sub-address");
    op_wr(3'd6, 8'h0D);
    op_rd(3'd5, "R9 sub bit 2 cleared, low bits from config");
    op_rd(3'd7, "R8 window follows config-written select");

    // R10: reserved selects and read-only next ID
    op_wr(3'd5, 8'h05); op_wr(3'd7, 8'hFF); op_rd(3'd7, "R10 reserved 101");
    op_wr(3'd5, 8'h06); op_rd(3'd7, "R10 reserved 110");
    op_wr(3'd5, 8'h07); op_rd(3'd7, "R10 reserved 111");
    op_wr(3'd5, 8'h04); op_rd(3'd7, "R10 setup 2 untouched by reserved write");
    pulse_evt(8'h00, 8'h00, 1'b1, 8'h77);
    op_wr(3'd5, 8'h03); op_wr(3'd7, 8'h99);
    op_rd(3'd7, "R10 next ID read-only");

    // R12: sticky event capture
    pulse_evt(8'h81, 8'h0C, 1'b0, 8'h00);
    pulse_evt(8'h24, 8'h30, 1'b0, 8'h00);
    op_rd(3'd0, "R12 status sticky");
    op_rd(3'd1, "R12 diag sticky");

    // R11: software reset scope
    op_wr(3'd6, 8'h87);
    chk({7'b0, soft_rst}, 8'h01, "R11 soft_rst high");
    pulse_evt(8'hFF, 8'hFF, 1'b1, 8'h55);
    op_rd(3'd0, "R11 status held");
    op_rd(3'd1, "R11 diag held");
    op_rd(3'd7, "R11 next ID held");
    op_rd(3'd6, "R11 config kept");
    op_rd(3'd3, "R11 pointer kept");
    op_wr(3'd5, 8'h01); op_rd(3'd7, "R11 node ID kept");
    op_wr(3'd6, 8'h00);
    chk({7'b0, soft_rst}, 8'h00, "R11 soft_rst released");
    pulse_evt(8'h10, 8'h02, 1'b0, 8'h00);
    op_rd(3'd0, "R11 status live after release");

    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [2:0] a;
      logic [7:0] d;
      int op;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom());
      op = $urandom_range(0, 9);
      if (op < 5) begin
        if (a == 3'd6) d[7] = ($urandom_range(0, 15) == 0);
        op_wr(a, d);
      end else if (op < 9) begin
        op_rd(a, "R5 random read");
      end else begin
        pulse_evt(8'($urandom()) & 8'h11, 8'($urandom()) & 8'h21,
                  1'($urandom()), 8'($urandom()));
      end
    end
    op_wr(3'd6, 8'h00);
    for (int a = 0; a < 8; a++) op_rd(3'(a), "R12 final readback");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule